// File: doc/BRIEF.md
# Keyed Two-Master Ownership Semaphore

This block decides which of two bus masters holds exclusive use of one shared resource. Each master has its own write strobe and 32-bit write data. The block keeps a single two-bit owner register, and both masters can read it back. A write changes ownership only when its upper half-word carries a fixed 16-bit key. The low two bits of the write then hold a master code, or zero to give the resource up.

Master A has code 2 and master B has code 1. Code 0 means the resource is free. To claim the resource, software writes the key together with its own code, then reads back the owner field. It repeats this until the field shows its own code. To give the resource up, the owning master writes the key with a zero field.

A claim succeeds only while the resource is free. A release succeeds only when the owner itself writes it. Every other write leaves the owner unchanged.

Top module: `keyed_owner_sem`

## Requirements
- R1: The active-low asynchronous reset clears the owner to 0 (free), and `rdata_o` reads 0.
- R2: A write whose bits [31:16] differ from the key 0x5A5A has no effect on the owner.
- R3: A keyed write from master A with low field 2, or from master B with low field 1, makes that master the owner at the next clock edge if the owner is 0.
- R4: A keyed claim made while the resource is already owned leaves the owner unchanged. This includes a repeated claim by the current owner.
- R5: A keyed write with low field 0 from the current owner sets the owner to 0 at the next clock edge.
- R6: A keyed release from the master that does not own the resource is ignored.
- R7: A keyed write whose low field is 3 is ignored. A keyed write whose low field names the other master's code is also ignored.
- R8: When both masters write a valid claim in the same cycle while the resource is free, master A becomes the owner.
- R9: When the owner writes a release and the other master writes a claim in the same cycle, the claim is judged against the owner held before that edge. The resource therefore ends up free.
- R10: Write bits [15:2] are ignored. `rdata_o` carries the owner in bits [1:0], and its bits [31:2] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_a_i | input | 1 | Master A write strobe |
| wdata_a_i | input | 32 | Master A write data (key in [31:16], code in [1:0]) |
| wr_b_i | input | 1 | Master B write strobe |
| wdata_b_i | input | 32 | Master B write data (key in [31:16], code in [1:0]) |
| rdata_o | output | 32 | Read-back; current owner code in [1:0] |

## Verification
Two pairs of operations can land in the same cycle.

The first pair is two claims made while the resource is free. The bench strobes both masters with valid keyed claims on one edge and expects code 2 on the next read.

The second pair is a release by the owner and a claim by the other master. The bench drives both on one edge and expects the owner to read 0, because the claim is judged against the owner held before that edge. The bench runs this case once with master A as the owner and once with master B.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned KEY_W  = 16;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned NUM_MST = 2;

  typedef enum logic [CODE_W-1:0] {
    OWN_NONE = 2'd0,
    OWN_B    = 2'd1,
    OWN_A    = 2'd2,
    OWN_BAD  = 2'd3
  } owner_e;

  typedef struct packed {
    logic claim;
    logic rel;
  } req_t;
endpackage

// File: rtl/sem_req_decode.sv
module sem_req_decode
  import sem_pkg::*;
#(
  parameter int unsigned            DW      = DATA_W,
  parameter int unsigned            KW      = KEY_W,
  parameter logic [KEY_W-1:0]       KEY     = 16'h5A5A,
  parameter logic [CODE_W-1:0]      MY_CODE = 2'd2
) (
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output req_t          req_o
);
  logic              key_ok;
  logic [CODE_W-1:0] field;

  assign key_ok = (wdata_i[DW-1 -: KW] == KW'(KEY));
  assign field  = wdata_i[CODE_W-1:0];

  // other-master codes and code 3 fall through as no request
  assign req_o.claim = wr_i && key_ok && (field == MY_CODE);
  assign req_o.rel   = wr_i && key_ok && (field == CODE_W'(0));
endmodule

// File: rtl/sem_arbiter.sv
module sem_arbiter
  import sem_pkg::*;
(
  input  owner_e owner_q_i,
  input  req_t   req_a_i,
  input  req_t   req_b_i,
  output owner_e owner_d_o
);
  always_comb begin
    owner_d_o = owner_q_i;
    unique case (owner_q_i)
      OWN_NONE: begin
        if (req_a_i.claim)      owner_d_o = OWN_A;  // A wins a tie
        else if (req_b_i.claim) owner_d_o = OWN_B;
      end
      OWN_A:   if (req_a_i.rel) owner_d_o = OWN_NONE;
      OWN_B:   if (req_b_i.rel) owner_d_o = OWN_NONE;
      default: owner_d_o = OWN_NONE;
    endcase
  end
endmodule

// File: rtl/sem_owner_reg.sv
module sem_owner_reg
  import sem_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  owner_e owner_d_i,
  input  req_t   req_a_i,
  input  req_t   req_b_i,
  output owner_e owner_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q_o <= OWN_NONE;
    else         owner_q_o <= owner_d_i;
  end

  assert_code_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_q_o != OWN_BAD);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_a_i.claim || req_a_i.rel || req_b_i.claim || req_b_i.rel)
    |=> $stable(owner_q_o));

  assert_a_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q_o == OWN_A && !req_a_i.rel) |=> owner_q_o == OWN_A);

  assert_b_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q_o == OWN_B && !req_b_i.rel) |=> owner_q_o == OWN_B);

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q_o == OWN_A && req_a_i.rel) |=> owner_q_o == OWN_NONE);

  assert_tie_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q_o == OWN_NONE && req_a_i.claim) |=> owner_q_o == OWN_A);

  assert_claim_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q_o == OWN_NONE && req_b_i.claim && !req_a_i.claim) |=> owner_q_o == OWN_B);
endmodule

// File: rtl/keyed_owner_sem.sv
module keyed_owner_sem
  import sem_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 16'h5A5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CODE_W;

  logic              wr   [NUM_MST];
  logic [DATA_W-1:0] wdata[NUM_MST];
  req_t              req  [NUM_MST];
  owner_e            owner_q, owner_d;

  assign wr[0]    = wr_a_i;
  assign wdata[0] = wdata_a_i;
  assign wr[1]    = wr_b_i;
  assign wdata[1] = wdata_b_i;

  // index 0 is master A (code 2), index 1 is master B (code 1)
  for (genvar m = 0; m < NUM_MST; m++) begin : g_dec
    sem_req_decode #(
      .DW     (DATA_W),
      .KW     (KEY_W),
      .KEY    (KEY),
      .MY_CODE(CODE_W'(NUM_MST - m))
    ) u_dec (
      .wr_i   (wr[m]),
      .wdata_i(wdata[m]),
      .req_o  (req[m])
    );
  end

  sem_arbiter u_arb (
    .owner_q_i(owner_q),
    .req_a_i  (req[0]),
    .req_b_i  (req[1]),
    .owner_d_o(owner_d)
  );

  sem_owner_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .owner_d_i(owner_d),
    .req_a_i  (req[0]),
    .req_b_i  (req[1]),
    .owner_q_o(owner_q)
  );

  assign rdata_o = {PAD_W'(0), owner_q};
endmodule

// File: tb/keyed_owner_sem_bench.sv
`timescale 1ns/1ps
module keyed_owner_sem_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wa = 1'b0, wb = 1'b0;
  logic [31:0] da = '0, db = '0;
  logic [31:0] rdata;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  keyed_owner_sem u_keyed_owner_sem (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_a_i(wa), .wdata_a_i(da),
    .wr_b_i(wb), .wdata_b_i(db),
    .rdata_o(rdata)
  );

  typedef struct packed {
    logic        wa;
    logic [31:0] da;
    logic        wb;
    logic [31:0] db;
    logic [1:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h1234_0002, 1'b0, 32'h0, 2'd0, 8'd2},   // R2 bad key
    '{1'b1, 32'h5A5A_0002, 1'b0, 32'h0, 2'd2, 8'd3},   // R3 A claims
    '{1'b0, 32'h0, 1'b1, 32'h5A5A_0001, 2'd2, 8'd4},   // R4 B claims busy
    '{1'b0, 32'h0, 1'b1, 32'h5A5A_0000, 2'd2, 8'd6},   // R6 B releases A's
    '{1'b1, 32'hA5A5_0000, 1'b0, 32'h0, 2'd2, 8'd2},   // R2 bad-key release
    '{1'b1, 32'h5A5A_0000, 1'b0, 32'h0, 2'd0, 8'd5},   // R5 A releases
    '{1'b0, 32'h0, 1'b1, 32'h5A5A_0001, 2'd1, 8'd3},   // R3 B claims
    '{1'b1, 32'h5A5A_0002, 1'b0, 32'h0, 2'd1, 8'd4},   // R4 A claims busy
    '{1'b1, 32'h5A5A_0000, 1'b0, 32'h0, 2'd1, 8'd6},   // R6 A releases B's
    '{1'b0, 32'h0, 1'b1, 32'h5A5A_FFFC, 2'd0, 8'd10},  // R10 junk bits, release
    '{1'b1, 32'h5A5A_0003, 1'b0, 32'h0, 2'd0, 8'd7},   // R7 code 3
    '{1'b1, 32'h5A5A_0001, 1'b0, 32'h0, 2'd0, 8'd7},   // R7 A names B
    '{1'b1, 32'h5A5A_0002, 1'b1, 32'h5A5A_0001, 2'd2, 8'd8}, // R8 tie
    '{1'b1, 32'h5A5A_0000, 1'b1, 32'h5A5A_0001, 2'd0, 8'd9}, // R9 A rel + B claim
    '{1'b0, 32'h0, 1'b1, 32'h5A5A_0001, 2'd1, 8'd3},   // R3 B claims
    '{1'b0, 32'h0, 1'b1, 32'h5A5A_7FF1, 2'd1, 8'd4},   // R4 owner re-claims
    '{1'b1, 32'h5A5A_0002, 1'b1, 32'h5A5A_0000, 2'd0, 8'd9}, // R9 B rel + A claim
    '{1'b1, 32'h5A5B_0002, 1'b0, 32'h0, 2'd0, 8'd2},   // R2 near-key
    '{1'b1, 32'h5A5A_0006, 1'b0, 32'h0, 2'd2, 8'd10}   // R10 junk bits, claim
  };

  task automatic check(input logic [31:0] exp, input int rq, input string what);
    n_vec++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: rdata=%h expected=%h", rq, what, rdata, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R0 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check(32'h0, 1, "in reset");                     // R1
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(32'h0, 1, "after reset release");          // R1

    for (int i = 0; i < NV; i++) begin
      wa = VECS[i].wa; da = VECS[i].da;
      wb = VECS[i].wb; db = VECS[i].db;
      @(negedge clk);
      check({30'b0, VECS[i].exp}, int'(VECS[i].req), $sformatf("vector %0d", i));
    end
    wa = 1'b0; wb = 1'b0; da = '0; db = '0;

    // R1: asynchronous reset while owned
    @(negedge clk);
    check(32'h2, 1, "owned before reset");
    #1 rst_n = 1'b0;
    #1 check(32'h0, 1, "async clear");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: keyless write with strobe held several cycles
    wb = 1'b1; db = 32'h0000_0001;
    repeat (3) @(negedge clk);
    wb = 1'b0;
    check(32'h0, 2, "held keyless claim");

    // R3 then R10 upper bits zero with B owning
    wb = 1'b1; db = 32'h5A5A_0001;
    @(negedge clk);
    wb = 1'b0;
    check(32'h1, 10, "B owner readback");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule